// File: doc/BRIEF.md
# Filtered Edge Interrupt Latch

This block takes an active-low interrupt pin that is asynchronous to the core clock and turns it into one pending-interrupt flag for the processor. The pin first passes through a two-stage synchroniser. A qualifier then counts consecutive low samples of the synchronised level. Only a low level that lasts long enough counts as a falling edge, so a one-cycle glitch is rejected.

When a qualified edge is seen, the pending flag is set. It stays set until the processor pulses a service-start strobe at the entry of its service routine. The qualifier then stays disarmed until the pin has been seen high again. A pin that stays low therefore raises exactly one interrupt. Priority, vectoring and masking belong to the logic that consumes the flag.

Top module: `irq_edge_latch`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it is released, `irq_pending` is 0.
- R2: A pin that goes low just before rising edge k and stays low sets `irq_pending` after rising edge k+3. Edges k and k+1 sample the pin, edges k+2 and k+3 count two synchronised low levels, and the flag is still 0 after edge k+2.
- R3: A pin that is low for only one sampling edge never sets `irq_pending`. The low-run counter restarts on the next high sample.
- R4: A pin held low after its interrupt has been cleared raises no second interrupt, however long it stays low.
- R5: A one-cycle `svc_start` pulse with no new qualified edge clears `irq_pending` on the next rising edge.
- R6: After the pin has been high for at least two sampling edges, a new qualified fall raises a new interrupt.
- R7: If `svc_start` and a new qualified edge fall in the same cycle, `irq_pending` stays 1.
- R8: The synchroniser resets to the asserted (low) level and the qualifier resets disarmed. A pin that is already low when reset is released raises no interrupt until it has gone high and fallen again.
- R9: `svc_start` while `irq_pending` is 0 and no edge is qualifying leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Raw asynchronous interrupt pin, asserted low |
| svc_start | input | 1 | One-cycle strobe: service routine has started |
| irq_pending | output | 1 | Pending-interrupt flag |

## Verification
The set from a newly qualified edge and the clear from `svc_start` can fall on the same rising edge. The bench provokes this as follows. It raises a first interrupt and re-arms the pin by taking it high. It then drops the pin again and times a one-cycle `svc_start` so that it is high during the cycle in which the second low sample is counted. The flag must read 1 after that edge, and a later lone `svc_start` must clear it. This shows that the set won and that nothing was stuck.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;

    typedef enum logic {
        ARM_WAIT_HIGH = 1'b0,
        ARM_READY     = 1'b1
    } arm_state_e;

    typedef struct packed {
        logic level;   // synchronised pin value, 0 = asserted
        logic fire;    // one-cycle qualified falling edge
    } qual_out_t;

    function automatic int cnt_width(input int max_count);
        return (max_count < 2) ? 1 : $clog2(max_count + 1);
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_low_qualifier.sv
module irq_low_qualifier
    import irq_edge_pkg::*;
#(
    parameter int MIN_LOW = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      level,
    output qual_out_t q
);
    localparam int CNT_W = cnt_width(MIN_LOW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_LOW - 1);

    arm_state_e       arm_q;
    logic [CNT_W-1:0] run_q;
    logic             fire;

    always_comb begin
        fire = (arm_q == ARM_READY) && !level && (run_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= ARM_WAIT_HIGH;
            run_q <= '0;
        end else if (level) begin
            arm_q <= ARM_READY;
            run_q <= '0;
        end else if (fire) begin
            arm_q <= ARM_WAIT_HIGH;
            run_q <= '0;
        end else if (arm_q == ARM_READY) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign q.level = level;
    assign q.fire  = fire;
endmodule

// File: rtl/irq_pending_flag.sv
module irq_pending_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst)          pending <= 1'b0;
        else if (set_evt) pending <= 1'b1;   // set wins over clear
        else if (clr_evt) pending <= 1'b0;
    end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
    import irq_edge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic irq_pin_n,
    input  logic svc_start,
    output logic irq_pending
);
    logic      sync_level;
    qual_out_t qual;
    logic      qual_fire;

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (irq_pin_n),
        .pin_sync  (sync_level)
    );

    irq_low_qualifier #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk   (clk),
        .rst   (rst),
        .level (sync_level),
        .q     (qual)
    );

    assign qual_fire = qual.fire;

    irq_pending_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (qual_fire),
        .clr_evt (svc_start),
        .pending (irq_pending)
    );
endmodule

// File: rtl/irq_edge_latch_chk.sv
module irq_edge_latch_chk #(
    parameter int MIN_LOW = 2
) (
    input logic clk,
    input logic rst,
    input logic svc_start,
    input logic irq_pending,
    input logic sync_level,
    input logic qual_fire
);
    localparam int RUN_W = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW + 1);

    logic [RUN_W-1:0] low_run;
    logic             seen_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run   <= '0;
            seen_high <= 1'b0;
        end else begin
            if (sync_level)                    low_run <= '0;
            else if (low_run != RUN_W'(MIN_LOW)) low_run <= low_run + 1'b1;
            if (sync_level)     seen_high <= 1'b1;
            else if (qual_fire) seen_high <= 1'b0;
        end
    end

    // R2, R3: a fire needs MIN_LOW consecutive low synchronised samples
    p_fire_needs_run_r3: assert property (@(posedge clk) disable iff (rst)
        qual_fire |-> (!sync_level && low_run == RUN_W'(MIN_LOW - 1)));

    // R4, R8: a fire needs a high level seen since the last fire or reset
    p_fire_needs_rearm_r4: assert property (@(posedge clk) disable iff (rst)
        qual_fire |-> seen_high);

    // R2: a fire sets the flag on the next edge
    p_fire_sets_r2: assert property (@(posedge clk) disable iff (rst)
        qual_fire |=> irq_pending);

    // R7: a fire together with service start still leaves the flag set
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (qual_fire && svc_start) |=> irq_pending);

    // R5: a lone service start clears the flag
    p_svc_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (svc_start && !qual_fire) |=> !irq_pending);

    // R9: with no event the flag holds its value
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!svc_start && !qual_fire) |=> $stable(irq_pending));

    // R2: the flag rises only after a fire
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pending) |-> $past(qual_fire));
endmodule

bind irq_edge_latch irq_edge_latch_chk #(.MIN_LOW(MIN_LOW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .svc_start   (svc_start),
    .irq_pending (irq_pending),
    .sync_level  (sync_level),
    .qual_fire   (qual_fire)
);

// File: tb/irq_edge_latch_tb.sv
`timescale 1ns/1ps
module irq_edge_latch_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_pin_n = 1'b1;
    logic svc_start = 1'b0;
    logic irq_pending;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_edge_latch u_dut (
        .clk         (clk),
        .rst         (rst),
        .irq_pin_n   (irq_pin_n),
        .svc_start   (svc_start),
        .irq_pending (irq_pending)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_pending=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // all driving and sampling at falling edges
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic pin_val);
        irq_pin_n = pin_val;
        svc_start = 1'b0;
        rst = 1'b1;
        tick(4);
        check("R1 in reset", irq_pending, 1'b0);
        rst = 1'b0;
        tick(1);
        check("R1 after release", irq_pending, 1'b0);
        tick(4);
    endtask

    task automatic pulse_svc();
        svc_start = 1'b1;
        tick(1);
        svc_start = 1'b0;
    endtask

    task automatic t_basic_latency();
        do_reset(1'b1);
        irq_pin_n = 1'b0;
        tick(3);
        check("R2 not yet after 3 edges", irq_pending, 1'b0);
        tick(1);
        check("R2 set after 4 edges", irq_pending, 1'b1);
        pulse_svc();
        check("R5 cleared by service start", irq_pending, 1'b0);
        irq_pin_n = 1'b1;
        tick(4);
    endtask

    task automatic t_glitch();
        do_reset(1'b1);
        irq_pin_n = 1'b0;
        tick(1);
        irq_pin_n = 1'b1;
        tick(8);
        check("R3 single-cycle glitch ignored", irq_pending, 1'b0);
        // two separated one-cycle lows must not add up
        irq_pin_n = 1'b0; tick(1);
        irq_pin_n = 1'b1; tick(1);
        irq_pin_n = 1'b0; tick(1);
        irq_pin_n = 1'b1; tick(8);
        check("R3 counter restarts on high", irq_pending, 1'b0);
    endtask

    task automatic t_held_low();
        do_reset(1'b1);
        irq_pin_n = 1'b0;
        tick(4);
        check("R4 first interrupt", irq_pending, 1'b1);
        pulse_svc();
        tick(30);
        check("R4 held low no second interrupt", irq_pending, 1'b0);
        pulse_svc();
        check("R9 svc while idle keeps 0", irq_pending, 1'b0);
        irq_pin_n = 1'b1;
        tick(3);
        irq_pin_n = 1'b0;
        tick(4);
        check("R6 re-armed after high", irq_pending, 1'b1);
        pulse_svc();
        irq_pin_n = 1'b1;
        tick(4);
    endtask

    task automatic t_collision();
        do_reset(1'b1);
        irq_pin_n = 1'b0;
        tick(4);
        check("R7 setup first interrupt", irq_pending, 1'b1);
        irq_pin_n = 1'b1;
        tick(3);
        irq_pin_n = 1'b0;
        tick(3);               // fire is active in this cycle
        svc_start = 1'b1;
        tick(1);
        svc_start = 1'b0;
        check("R7 set wins over service start", irq_pending, 1'b1);
        tick(2);
        check("R7 flag holds", irq_pending, 1'b1);
        pulse_svc();
        check("R5 later clear works", irq_pending, 1'b0);
        irq_pin_n = 1'b1;
        tick(4);
    endtask

    task automatic t_low_at_reset();
        do_reset(1'b0);
        tick(10);
        check("R8 low through reset gives no interrupt", irq_pending, 1'b0);
        irq_pin_n = 1'b1;
        tick(3);
        irq_pin_n = 1'b0;
        tick(4);
        check("R8 interrupt after high then fall", irq_pending, 1'b1);
        irq_pin_n = 1'b1;
        tick(2);
    endtask

    initial begin
        tick(1);
        t_basic_latency();
        t_glitch();
        t_held_low();
        t_collision();
        t_low_at_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule